// File: doc/BRIEF.md
# Seconds Real-Time Clock with Match Alarms

This peripheral keeps elapsed time as a count of seconds. It has two 32-bit counters. One counts up and one counts down, and both advance on a one-second tick pulse that arrives from outside. Software loads the two counters as a complementary pair, so their sum is all ones. Two compare registers watch the up-counter. An equality on a channel that is enabled latches a status flag and can raise the interrupt. A channel can also be routed to a latched power-on request. A free 32-bit seal word keeps its value through a hardware reset, so boot code can tell whether the domain was already set up. The conventional seal value is 0xB5C13F27.

Software reaches every register through a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. Counting can be frozen so that software can load the counters safely. A software reset bit holds both counters at their starting values.

Top module: `secs_rtc`

## Requirements
- R1: After hardware reset the following values hold. Control and status read 0. The up-counter reads 0 and the down-counter reads 0xFFFFFFFF. Both compare registers read 0xFFFFFFFF. The `irq` and `pwr_on` outputs are low.
- R2: The byte addresses are: up-counter 0x00, down-counter 0x04, compare 0 0x08, compare 1 0x0C, control 0x10, status 0x14, seal 0x18. Any other address reads 0, and a write to it has no effect.
- R3: The counters advance when control bit 6 is 0 and control bit 4 is 0. On each cycle with `tick` high, the up-counter adds one and the down-counter subtracts one. Both wrap modulo 2^32.
- R4: While control bit 6 is 1, neither counter changes on a tick, and bus writes load the counters. While bit 6 is 0, writes to either counter are ignored.
- R5: While control bit 4 is 1, the up-counter is held at 0 and the down-counter at 0xFFFFFFFF, whatever the tick or the writes do.
- R6: Suppose channel n (n = 0 or 1) has control bit n set and the up-counter equals compare n at a clock edge. Status bit n reads 1 from that edge onward. The flag sets again on every cycle in which the equality still holds.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A clear in the same cycle as a new set wins, so the bit reads 0 for one cycle. Loading 0xFFFFFFFF into the compare register stops it from setting again.
- R8: `irq` is high exactly when status bit 0 and control bit 0 are both 1, or when status bit 1 and control bit 1 are both 1.
- R9: Control bit 2 (for channel 0) and control bit 3 (for channel 1) make an equality on that channel set status bit 2. This does not depend on control bits 0 and 1. `pwr_on` is high when status bit 2 is 1 or when control bit 7 is 1.
- R10: The seal register at 0x18 reads back any 32-bit word written to it. A hardware reset does not change its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse once per second |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt request from the enabled match flags |
| pwr_on | output | 1 | Power-on request output |

## Verification
A counter that loses its step, or that moves while frozen or under software reset, shows up on the very next bus read of either counter. A read after two ticks also shows whether the up and down values have stopped summing to all ones. A wrong compare or status path first appears one clock after the up-counter reaches the compare value, as a missing or early `irq` or `pwr_on`. Reading the status register just after a write-one-to-clear, and again one cycle later, shows whether the clear is ignored and whether the flag sets again while the equality still holds. The seal word is read back across a reset pulse, so any reset wired to it is exposed at once.

// File: rtl/secs_rtc_pkg.sv
// Shared constants for the seconds RTC: register byte offsets,
// control bit positions and the conventional seal value.
package secs_rtc_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned N_MATCH = 2;

    localparam int unsigned OFS_UP   = 'h00;
    localparam int unsigned OFS_DN   = 'h04;
    localparam int unsigned OFS_CMP0 = 'h08;
    localparam int unsigned OFS_CMP1 = 'h0C;
    localparam int unsigned OFS_CTL  = 'h10;
    localparam int unsigned OFS_ST   = 'h14;
    localparam int unsigned OFS_SEAL = 'h18;

    // control bits: [0..N_MATCH-1] interrupt enables, [2..3] power-on routes
    localparam int unsigned CB_PWR0  = 2;
    localparam int unsigned CB_SWRST = 4;
    localparam int unsigned CB_FREEZE = 6;
    localparam int unsigned CB_FORCE = 7;
    localparam logic [7:0]  CTL_MASK = 8'hDF;

    localparam int unsigned SB_PWR   = 2;
    localparam int unsigned ST_W     = 3;

    localparam logic [31:0] SEAL_WORD = 32'hB5C13F27;
endpackage

// File: rtl/secs_rtc_count.sv
// Complementary seconds counter pair.
// Assumes: the caller gates the load strobes with the freeze bit; the
// software reset beats a load, and a load beats a tick.
module secs_rtc_count #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_zero,
    input  logic         run,
    input  logic         tick,
    input  logic         ld_up,
    input  logic         ld_dn,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] up_q,
    output logic [W-1:0] dn_q
);
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    // up-counter: reset, load or increment on tick
    always_ff @(posedge clk) begin
        if (!rst_n || hold_zero) begin
            up_q <= '0;
        end else if (ld_up) begin
            up_q <= wdata;
        end else if (run && tick) begin
            up_q <= up_q + ONE;
        end
    end

    // down-counter: reset, load or decrement on tick
    always_ff @(posedge clk) begin
        if (!rst_n || hold_zero) begin
            dn_q <= ONES;
        end else if (ld_dn) begin
            dn_q <= wdata;
        end else if (run && tick) begin
            dn_q <= dn_q - ONE;
        end
    end
endmodule

// File: rtl/secs_rtc_cmp.sv
// One compare channel: holds a compare word and flags equality with
// the running up-counter. Assumes the compare word is all ones after reset.
module secs_rtc_cmp #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] count,
    output logic [W-1:0] cmp_q,
    output logic         hit
);
    // compare register: reset to all ones, load from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= {W{1'b1}};
        end else if (ld) begin
            cmp_q <= wdata;
        end
    end

    // equality against the live count
    always_comb hit = (count == cmp_q);
endmodule

// File: rtl/secs_rtc.sv
// Seconds real-time clock: register decode, control, sticky status,
// seal word, interrupt and power-on outputs.
// Assumes: tick is a single-cycle pulse synchronous to clk; reads are
// combinational; the seal word is left alone by the hardware reset.
module secs_rtc
    import secs_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              pwr_on
);
    localparam int unsigned W = DATA_W;

    logic [7:0]      ctl_q;
    logic [ST_W-1:0] st_q;
    logic [W-1:0]    seal_q;
    logic [W-1:0]    up_q, dn_q;
    logic [W-1:0]    cmp_q [N_MATCH];
    logic [N_MATCH-1:0] hit;
    logic            sel_up, sel_dn, sel_ctl, sel_st, sel_seal;
    logic [N_MATCH-1:0] sel_cmp;
    logic            frozen;
    logic [ST_W-1:0] st_set, st_clr;

    // address decode
    always_comb begin
        sel_up   = (bus_addr == ADDR_W'(OFS_UP));
        sel_dn   = (bus_addr == ADDR_W'(OFS_DN));
        sel_ctl  = (bus_addr == ADDR_W'(OFS_CTL));
        sel_st   = (bus_addr == ADDR_W'(OFS_ST));
        sel_seal = (bus_addr == ADDR_W'(OFS_SEAL));
        sel_cmp[0] = (bus_addr == ADDR_W'(OFS_CMP0));
        sel_cmp[1] = (bus_addr == ADDR_W'(OFS_CMP1));
        frozen   = ctl_q[CB_FREEZE];
    end

    secs_rtc_count #(.W(W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (ctl_q[CB_SWRST]),
        .run       (!frozen),
        .tick      (tick),
        .ld_up     (bus_we && sel_up && frozen),
        .ld_dn     (bus_we && sel_dn && frozen),
        .wdata     (bus_wdata),
        .up_q      (up_q),
        .dn_q      (dn_q)
    );

    for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
        secs_rtc_cmp #(.W(W)) u_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (bus_we && sel_cmp[i]),
            .wdata (bus_wdata),
            .count (up_q),
            .cmp_q (cmp_q[i]),
            .hit   (hit[i])
        );
    end

    // status set and write-one-to-clear terms
    always_comb begin
        st_set = '0;
        for (int i = 0; i < N_MATCH; i++) begin
            st_set[i] = hit[i] && ctl_q[i];
            if (hit[i] && ctl_q[CB_PWR0 + i]) st_set[SB_PWR] = 1'b1;
        end
        st_clr = (bus_we && sel_st) ? bus_wdata[ST_W-1:0] : '0;
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (bus_we && sel_ctl) begin
            ctl_q <= bus_wdata[7:0] & CTL_MASK;
        end
    end

    // sticky status: sets from matches, a clear in the same cycle wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= (st_q | st_set) & ~st_clr;
        end
    end

    // seal word: bus writable, kept through hardware reset
    always_ff @(posedge clk) begin
        if (bus_we && sel_seal) begin
            seal_q <= bus_wdata;
        end
    end

    // read mux, zero for unmapped addresses
    always_comb begin
        bus_rdata = '0;
        if (sel_up)     bus_rdata = up_q;
        if (sel_dn)     bus_rdata = dn_q;
        if (sel_cmp[0]) bus_rdata = cmp_q[0];
        if (sel_cmp[1]) bus_rdata = cmp_q[1];
        if (sel_ctl)    bus_rdata = W'(ctl_q);
        if (sel_st)     bus_rdata = W'(st_q);
        if (sel_seal)   bus_rdata = seal_q;
    end

    // outputs
    always_comb begin
        irq    = |(st_q[N_MATCH-1:0] & ctl_q[N_MATCH-1:0]);
        pwr_on = st_q[SB_PWR] || ctl_q[CB_FORCE];
    end
endmodule

// File: rtl/secs_rtc_chk.sv
// Property checker for secs_rtc, bound into every instance.
// Assumes it sees the internal control, status, counter and compare state.
module secs_rtc_chk
    import secs_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [7:0]        ctl_q,
    input logic [ST_W-1:0]   st_q,
    input logic [DATA_W-1:0] up_q,
    input logic [DATA_W-1:0] dn_q,
    input logic [DATA_W-1:0] cmp0_q
);
    p_tick_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[CB_FREEZE] && !ctl_q[CB_SWRST] && tick)
        |=> (up_q == $past(up_q) + 32'd1) && (dn_q == $past(dn_q) - 32'd1));

    p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[CB_FREEZE] && !ctl_q[CB_SWRST]
         && !(bus_we && bus_addr == ADDR_W'(OFS_UP)))
        |=> $stable(up_q));

    p_run_load_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[CB_FREEZE] && !ctl_q[CB_SWRST] && !tick && bus_we
         && bus_addr == ADDR_W'(OFS_UP))
        |=> $stable(up_q));

    p_swreset_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[CB_SWRST] |=> (up_q == '0) && (dn_q == '1));

    p_match_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[0] && up_q == cmp0_q
         && !(bus_we && bus_addr == ADDR_W'(OFS_ST) && bus_wdata[0]))
        |=> st_q[0]);
endmodule

bind secs_rtc secs_rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .ctl_q     (ctl_q),
    .st_q      (st_q),
    .up_q      (up_q),
    .dn_q      (dn_q),
    .cmp0_q    (cmp_q[0])
);

// File: tb/secs_rtc_bench.sv
// Directed bench for secs_rtc: one task per scenario, each self-checking.
module secs_rtc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, pwr_on;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    secs_rtc u_secs_rtc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .pwr_on(pwr_on)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(5'h10, v); check("R1 ctl", v, 0);
        rd(5'h14, v); check("R1 status", v, 0);
        rd(5'h00, v); check("R1 up", v, 0);
        rd(5'h04, v); check("R1 down", v, 32'hFFFFFFFF);
        rd(5'h08, v); check("R1 cmp0", v, 32'hFFFFFFFF);
        rd(5'h0C, v); check("R1 cmp1", v, 32'hFFFFFFFF);
        check("R1 irq/pwr_on", {30'd0, irq, pwr_on}, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        do_reset();
        wr(5'h1C, 32'h12345678);
        rd(5'h1C, v); check("R2 unmapped 0x1C", v, 0);
        rd(5'h02, v); check("R2 unaligned 0x02", v, 0);
        rd(5'h10, v); check("R2 ctl untouched", v, 0);
    endtask

    task automatic t_count_and_wrap();
        logic [31:0] v;
        do_reset();
        ticks(3);
        rd(5'h00, v); check("R3 up after 3", v, 3);
        rd(5'h04, v); check("R3 down after 3", v, 32'hFFFFFFFC);
        wr(5'h10, 32'h40);
        wr(5'h00, 32'hFFFFFFFF);
        wr(5'h04, 32'h0);
        wr(5'h10, 32'h0);
        ticks(1);
        rd(5'h00, v); check("R3 up wrap", v, 0);
        rd(5'h04, v); check("R3 down wrap", v, 32'hFFFFFFFF);
    endtask

    task automatic t_freeze_and_load();
        logic [31:0] v;
        do_reset();
        wr(5'h00, 32'd77);
        rd(5'h00, v); check("R4 load ignored while running", v, 0);
        wr(5'h10, 32'h40);
        wr(5'h00, 32'd500);
        wr(5'h04, 32'hFFFFFFFF - 32'd500);
        ticks(4);
        rd(5'h00, v); check("R4 frozen up", v, 500);
        rd(5'h04, v); check("R4 frozen down", v, 32'hFFFFFFFF - 32'd500);
    endtask

    task automatic t_swreset();
        logic [31:0] v;
        do_reset();
        ticks(5);
        wr(5'h10, 32'h10);
        ticks(2);
        rd(5'h00, v); check("R5 up held", v, 0);
        rd(5'h04, v); check("R5 down held", v, 32'hFFFFFFFF);
    endtask

    task automatic t_match_irq();
        logic [31:0] v;
        do_reset();
        wr(5'h10, 32'h40);
        wr(5'h00, 32'd10);
        wr(5'h08, 32'd12);
        wr(5'h10, 32'h01);
        ticks(2);
        rd(5'h14, v); check("R6 not yet latched", v, 0);
        check("R8 irq low before latch", {31'd0, irq}, 0);
        @(negedge clk);
        rd(5'h14, v); check("R6 latched one cycle later", v, 1);
        check("R8 irq high", {31'd0, irq}, 1);
        wr(5'h14, 32'h1);
        rd(5'h14, v); check("R7 clear wins", v, 0);
        @(negedge clk);
        rd(5'h14, v); check("R6 relatch while equal", v, 1);
        wr(5'h10, 32'h00);
        check("R8 irq masked by enable", {31'd0, irq}, 0);
        wr(5'h10, 32'h41);
        wr(5'h08, 32'hFFFFFFFF);
        wr(5'h14, 32'h1);
        @(negedge clk); @(negedge clk);
        rd(5'h14, v); check("R7 stays clear after park", v, 0);
        check("R8 irq low after park", {31'd0, irq}, 0);
    endtask

    task automatic t_match1();
        logic [31:0] v;
        do_reset();
        wr(5'h10, 32'h42);
        wr(5'h00, 32'd9);
        wr(5'h0C, 32'd9);
        @(negedge clk);
        rd(5'h14, v); check("R6 match1 latched", v, 2);
        check("R8 irq from match1", {31'd0, irq}, 1);
    endtask

    task automatic t_power_on();
        logic [31:0] v;
        do_reset();
        wr(5'h10, 32'h44);
        wr(5'h00, 32'd5);
        wr(5'h08, 32'd5);
        @(negedge clk);
        rd(5'h14, v); check("R9 power event status", v, 4);
        check("R9 pwr_on set", {31'd0, pwr_on}, 1);
        check("R9 irq stays low", {31'd0, irq}, 0);
        wr(5'h08, 32'hFFFFFFFF);
        wr(5'h14, 32'h4);
        check("R9 pwr_on cleared", {31'd0, pwr_on}, 0);
        wr(5'h10, 32'hC0);
        check("R9 pwr_on forced", {31'd0, pwr_on}, 1);
    endtask

    task automatic t_seal();
        logic [31:0] v;
        do_reset();
        wr(5'h18, 32'hB5C13F27);
        rd(5'h18, v); check("R10 seal readback", v, 32'hB5C13F27);
        wr(5'h10, 32'h81);
        do_reset();
        rd(5'h18, v); check("R10 seal kept over reset", v, 32'hB5C13F27);
        rd(5'h10, v); check("R1 ctl cleared by reset", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_unmapped();
        t_count_and_wrap();
        t_freeze_and_load();
        t_swreset();
        t_match_irq();
        t_match1();
        t_power_on();
        t_seal();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule